// File: doc/BRIEF.md
# Dual-Location Atomic Compare-and-Update Memory Unit

This block is a small word-addressed RAM fronted by an atomic engine. A requester hands it two addresses, an expected value for each and a replacement value for each. The engine reads both words, compares each against its expected value, and only if both match writes both replacements. The requester gets back one pass/fail flag. No other access can see the pair half-updated.

A common use pairs a version counter with a pointer field. The first location holds the counter, and its replacement is the expected count plus one. The second location holds the pointer being swung. A failed flag tells software that something changed under it and that it should retry.

A second, plain read/write port shares the RAM through an arbiter. That port is held off for as long as an atomic operation is between its first read and its last write. When both ports present a request in the same idle cycle, the plain access goes to the RAM first.

Top module: `dcas_mem_unit`

## Requirements
- R1: After reset every RAM word reads zero, `dreq_ready_o` is high and neither response valid is asserted.
- R2: When word[addr_a] equals exp_a and word[addr_b] equals exp_b, new_a is stored at addr_a, new_b is stored at addr_b, and the response carries `drsp_ok_o` = 1.
- R3: When either comparison fails, neither word changes and the response carries `drsp_ok_o` = 0.
- R4: From the cycle after an atomic request is accepted until its response is presented, `preq_ready_o` stays low, so a plain access cannot interleave. A plain write held off this way lands after the atomic writes.
- R5: `drsp_valid_o` rises exactly 6 clock edges after the accepting edge on success, and exactly 4 edges after it on failure, because the writes are skipped.
- R6: A request with addr_a equal to addr_b succeeds only if both exp_a and exp_b equal the stored word. On success, new_b is the value left in the word.
- R7: `dreq_ready_o` goes low after acceptance and stays low until the response is taken (`drsp_valid_o` and `drsp_ready_i` both high). While the response is stalled, `drsp_valid_o` and `drsp_ok_o` hold steady.
- R8: An accepted plain access raises `prsp_valid_o` on the following cycle. For a read, `prsp_rdata_o` then holds the addressed word. A write stores its data. No `prsp_valid_o` appears without an accepted plain access.
- R9: When a plain access and an atomic request are both presented in the same idle cycle, the plain access takes effect first, and the atomic compare sees its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dreq_valid_i | input | 1 | Atomic request valid |
| dreq_ready_o | output | 1 | Atomic request accepted when high with valid |
| dreq_addr_a_i | input | ADDR_W | First location |
| dreq_addr_b_i | input | ADDR_W | Second location |
| dreq_exp_a_i | input | DATA_W | Expected value of first location |
| dreq_exp_b_i | input | DATA_W | Expected value of second location |
| dreq_new_a_i | input | DATA_W | Replacement for first location |
| dreq_new_b_i | input | DATA_W | Replacement for second location |
| drsp_valid_o | output | 1 | Atomic response valid |
| drsp_ready_i | input | 1 | Atomic response taken |
| drsp_ok_o | output | 1 | 1 = both matched and both written |
| preq_valid_i | input | 1 | Plain access valid |
| preq_ready_o | output | 1 | Plain access accepted when high with valid |
| preq_we_i | input | 1 | 1 = write, 0 = read |
| preq_addr_i | input | ADDR_W | Plain access address |
| preq_wdata_i | input | DATA_W | Plain write data |
| prsp_valid_o | output | 1 | Plain access completed |
| prsp_rdata_o | output | DATA_W | Plain read data |

## Verification
The assertions check the handshake rules on every cycle. These cover the one-in-flight rule and the stable stalled response, the hold-off of the plain port while an atomic operation is busy, the one-cycle plain response, and the 6- or 4-edge response timing tied to the flag. Whether the right words were written, or left alone, can only be shown by the bench scenarios. Those scenarios compare results against a sequential model of the RAM: both-match and single-mismatch cases, same-address requests, version-counter chains, simultaneous arrivals, a held-off plain write, and a long random interleaving.

// File: rtl/dcas_pkg.sv
package dcas_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_A,
    ST_RD_B,
    ST_CMP,
    ST_WR_A,
    ST_WR_B,
    ST_RESP
  } dcas_state_e;
endpackage

// File: rtl/dcas_ram.sv
module dcas_ram #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      rdata_o <= '0;
    end else if (en_i) begin
      if (we_i) mem_q[addr_i] <= wdata_i;
      else      rdata_o <= mem_q[addr_i];
    end
  end
endmodule

// File: rtl/dcas_seq.sv
module dcas_seq
  import dcas_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] addr_a_i,
  input  logic [ADDR_W-1:0] addr_b_i,
  input  logic [DATA_W-1:0] exp_a_i,
  input  logic [DATA_W-1:0] exp_b_i,
  input  logic [DATA_W-1:0] new_a_i,
  input  logic [DATA_W-1:0] new_b_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic              rsp_ok_o,
  output logic              lock_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  dcas_state_e       state_q, state_d;
  logic [ADDR_W-1:0] addr_a_q, addr_b_q;
  logic [DATA_W-1:0] exp_a_q, exp_b_q, new_a_q, new_b_q, val_a_q;
  logic              ok_q, match;

  assign match = (val_a_q == exp_a_q) && (mem_rdata_i == exp_b_q);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) state_d = ST_RD_A;
      ST_RD_A: state_d = ST_RD_B;
      ST_RD_B: state_d = ST_CMP;
      ST_CMP:  state_d = match ? ST_WR_A : ST_RESP;
      ST_WR_A: state_d = ST_WR_B;
      ST_WR_B: state_d = ST_RESP;
      ST_RESP: if (rsp_ready_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      addr_a_q <= '0;
      addr_b_q <= '0;
      exp_a_q  <= '0;
      exp_b_q  <= '0;
      new_a_q  <= '0;
      new_b_q  <= '0;
      val_a_q  <= '0;
      ok_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && req_valid_i) begin
        addr_a_q <= addr_a_i;
        addr_b_q <= addr_b_i;
        exp_a_q  <= exp_a_i;
        exp_b_q  <= exp_b_i;
        new_a_q  <= new_a_i;
        new_b_q  <= new_b_i;
      end
      // word A lands on rdata during RD_B, word B during CMP
      if (state_q == ST_RD_B) val_a_q <= mem_rdata_i;
      if (state_q == ST_CMP)  ok_q    <= match;
    end
  end

  always_comb begin
    mem_en_o    = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = addr_a_q;
    mem_wdata_o = new_a_q;
    unique case (state_q)
      ST_RD_A: mem_en_o = 1'b1;
      ST_RD_B: begin mem_en_o = 1'b1; mem_addr_o = addr_b_q; end
      ST_WR_A: begin mem_en_o = 1'b1; mem_we_o = 1'b1; end
      ST_WR_B: begin
        mem_en_o    = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = addr_b_q;
        mem_wdata_o = new_b_q;
      end
      default: ;
    endcase
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign rsp_valid_o = (state_q == ST_RESP);
  assign rsp_ok_o    = ok_q;
  assign lock_o      = (state_q != ST_IDLE) && (state_q != ST_RESP);
endmodule

// File: rtl/dcas_arb.sv
module dcas_arb #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lock_i,
  input  logic              seq_en_i,
  input  logic              seq_we_i,
  input  logic [ADDR_W-1:0] seq_addr_i,
  input  logic [DATA_W-1:0] seq_wdata_i,
  input  logic              preq_valid_i,
  output logic              preq_ready_o,
  input  logic              preq_we_i,
  input  logic [ADDR_W-1:0] preq_addr_i,
  input  logic [DATA_W-1:0] preq_wdata_i,
  output logic              prsp_valid_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  logic plain_go;

  // sequencer touches RAM only while it holds the lock
  assign preq_ready_o = !lock_i;
  assign plain_go     = preq_valid_i && preq_ready_o;

  always_comb begin
    if (lock_i) begin
      mem_en_o    = seq_en_i;
      mem_we_o    = seq_we_i;
      mem_addr_o  = seq_addr_i;
      mem_wdata_o = seq_wdata_i;
    end else begin
      mem_en_o    = plain_go;
      mem_we_o    = preq_we_i;
      mem_addr_o  = preq_addr_i;
      mem_wdata_o = preq_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prsp_valid_o <= 1'b0;
    else         prsp_valid_o <= plain_go;
  end
endmodule

// File: rtl/dcas_mem_unit.sv
module dcas_mem_unit #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dreq_valid_i,
  output logic              dreq_ready_o,
  input  logic [ADDR_W-1:0] dreq_addr_a_i,
  input  logic [ADDR_W-1:0] dreq_addr_b_i,
  input  logic [DATA_W-1:0] dreq_exp_a_i,
  input  logic [DATA_W-1:0] dreq_exp_b_i,
  input  logic [DATA_W-1:0] dreq_new_a_i,
  input  logic [DATA_W-1:0] dreq_new_b_i,
  output logic              drsp_valid_o,
  input  logic              drsp_ready_i,
  output logic              drsp_ok_o,
  input  logic              preq_valid_i,
  output logic              preq_ready_o,
  input  logic              preq_we_i,
  input  logic [ADDR_W-1:0] preq_addr_i,
  input  logic [DATA_W-1:0] preq_wdata_i,
  output logic              prsp_valid_o,
  output logic [DATA_W-1:0] prsp_rdata_o
);
  logic              lock;
  logic              seq_en, seq_we, mem_en, mem_we;
  logic [ADDR_W-1:0] seq_addr, mem_addr;
  logic [DATA_W-1:0] seq_wdata, mem_wdata, mem_rdata;

  dcas_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (dreq_valid_i),
    .req_ready_o (dreq_ready_o),
    .addr_a_i    (dreq_addr_a_i),
    .addr_b_i    (dreq_addr_b_i),
    .exp_a_i     (dreq_exp_a_i),
    .exp_b_i     (dreq_exp_b_i),
    .new_a_i     (dreq_new_a_i),
    .new_b_i     (dreq_new_b_i),
    .rsp_valid_o (drsp_valid_o),
    .rsp_ready_i (drsp_ready_i),
    .rsp_ok_o    (drsp_ok_o),
    .lock_o      (lock),
    .mem_en_o    (seq_en),
    .mem_we_o    (seq_we),
    .mem_addr_o  (seq_addr),
    .mem_wdata_o (seq_wdata),
    .mem_rdata_i (mem_rdata)
  );

  dcas_arb #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_arb (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .lock_i       (lock),
    .seq_en_i     (seq_en),
    .seq_we_i     (seq_we),
    .seq_addr_i   (seq_addr),
    .seq_wdata_i  (seq_wdata),
    .preq_valid_i (preq_valid_i),
    .preq_ready_o (preq_ready_o),
    .preq_we_i    (preq_we_i),
    .preq_addr_i  (preq_addr_i),
    .preq_wdata_i (preq_wdata_i),
    .prsp_valid_o (prsp_valid_o),
    .mem_en_o     (mem_en),
    .mem_we_o     (mem_we),
    .mem_addr_o   (mem_addr),
    .mem_wdata_o  (mem_wdata)
  );

  dcas_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (mem_en),
    .we_i    (mem_we),
    .addr_i  (mem_addr),
    .wdata_i (mem_wdata),
    .rdata_o (mem_rdata)
  );

  assign prsp_rdata_o = mem_rdata;
endmodule

// File: rtl/dcas_mem_unit_chk.sv
module dcas_mem_unit_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic dreq_valid_i,
  input logic dreq_ready_o,
  input logic drsp_valid_o,
  input logic drsp_ready_i,
  input logic drsp_ok_o,
  input logic preq_valid_i,
  input logic preq_ready_o,
  input logic prsp_valid_o
);
  logic [2:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                lat_q <= '0;
    else if (dreq_valid_i && dreq_ready_o)      lat_q <= 3'd1;
    else if (drsp_valid_o && drsp_ready_i)      lat_q <= '0;
    else if (lat_q != 0 && !drsp_valid_o)       lat_q <= lat_q + 3'd1;
  end

  // R1
  rst_state_chk: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> dreq_ready_o && !drsp_valid_o && !prsp_valid_o);

  // R7
  one_in_flight_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dreq_valid_i && dreq_ready_o) |=> !dreq_ready_o);

  // R7
  ready_until_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dreq_ready_o && !(drsp_valid_o && drsp_ready_i)) |=> !dreq_ready_o);

  // R7
  rsp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drsp_valid_o && !drsp_ready_i) |=> drsp_valid_o && $stable(drsp_ok_o));

  // R4
  plain_holdoff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dreq_ready_o && !drsp_valid_o) |-> !preq_ready_o);

  // R8
  plain_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (preq_valid_i && preq_ready_o) |=> prsp_valid_o);

  // R8
  plain_no_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(preq_valid_i && preq_ready_o) |=> !prsp_valid_o);

  // R5
  rsp_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drsp_valid_o) |-> ((drsp_ok_o && lat_q == 3'd6) || (!drsp_ok_o && lat_q == 3'd4)));
endmodule

bind dcas_mem_unit dcas_mem_unit_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .dreq_valid_i (dreq_valid_i),
  .dreq_ready_o (dreq_ready_o),
  .drsp_valid_o (drsp_valid_o),
  .drsp_ready_i (drsp_ready_i),
  .drsp_ok_o    (drsp_ok_o),
  .preq_valid_i (preq_valid_i),
  .preq_ready_o (preq_ready_o),
  .prsp_valid_o (prsp_valid_o)
);

// File: tb/dcas_mem_unit_test.sv
`timescale 1ns/1ps
module dcas_mem_unit_test;
  localparam int DW = 16;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic dreq_valid_i = 0, drsp_ready_i = 0, preq_valid_i = 0, preq_we_i = 0;
  logic [AW-1:0] dreq_addr_a_i = '0, dreq_addr_b_i = '0, preq_addr_i = '0;
  logic [DW-1:0] dreq_exp_a_i = '0, dreq_exp_b_i = '0, dreq_new_a_i = '0, dreq_new_b_i = '0;
  logic [DW-1:0] preq_wdata_i = '0;
  logic dreq_ready_o, drsp_valid_o, drsp_ok_o, preq_ready_o, prsp_valid_o;
  logic [DW-1:0] prsp_rdata_o;

  logic [DW-1:0] model [DEPTH];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  dcas_mem_unit #(.DATA_W(DW), .ADDR_W(AW)) uut (.*);

  task automatic check(input bit cond, input string req, input int act, input int exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic plain_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
    @(negedge clk_i);
    preq_valid_i = 1; preq_we_i = 1; preq_addr_i = a; preq_wdata_i = d;
    while (!preq_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    preq_valid_i = 0; preq_we_i = 0;
    check(prsp_valid_o, req, prsp_valid_o, 1);
    model[a] = d;
  endtask

  task automatic plain_read(input logic [AW-1:0] a, input string req);
    @(negedge clk_i);
    preq_valid_i = 1; preq_we_i = 0; preq_addr_i = a;
    while (!preq_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    preq_valid_i = 0;
    check(prsp_valid_o && prsp_rdata_o == model[a], req, prsp_rdata_o, model[a]);
  endtask

  // drive one atomic request, check flag, latency and hold-off; update model
  task automatic dcas(input logic [AW-1:0] a, b, input logic [DW-1:0] ea, eb, na, nb,
                      input int stall, input string req);
    bit exp_ok;
    int lat;
    bit leak;
    exp_ok = (model[a] == ea) && (model[b] == eb);
    @(negedge clk_i);
    dreq_valid_i = 1; dreq_addr_a_i = a; dreq_addr_b_i = b;
    dreq_exp_a_i = ea; dreq_exp_b_i = eb; dreq_new_a_i = na; dreq_new_b_i = nb;
    while (!dreq_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    dreq_valid_i = 0;
    lat = 1; leak = 0;
    while (!drsp_valid_o && lat < 20) begin
      if (preq_ready_o || dreq_ready_o) leak = 1;
      @(negedge clk_i);
      lat++;
    end
    check(drsp_ok_o == exp_ok, {req, " ok flag"}, drsp_ok_o, exp_ok);
    check(lat == (exp_ok ? 6 : 4), "R5 latency", lat, exp_ok ? 6 : 4);
    check(!leak, "R4 plain port held off", leak, 0);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk_i);
      check(drsp_valid_o && drsp_ok_o == exp_ok && !dreq_ready_o, "R7 stalled response",
            drsp_ok_o, exp_ok);
    end
    drsp_ready_i = 1;
    @(negedge clk_i);
    drsp_ready_i = 0;
    check(dreq_ready_o && !drsp_valid_o, "R7 ready after response", dreq_ready_o, 1);
    if (exp_ok) begin model[a] = na; model[b] = nb; end
  endtask

  task automatic t_reset;
    check(dreq_ready_o && !drsp_valid_o && !prsp_valid_o, "R1 idle outputs", dreq_ready_o, 1);
    for (int i = 0; i < DEPTH; i += 5) plain_read(i[AW-1:0], "R1 zero word");
  endtask

  task automatic t_plain;
    plain_write(4'd3, 16'h1234, "R8 write resp");
    plain_read(4'd3, "R8 read back");
    plain_write(4'd9, 16'hbeef, "R8 write resp");
    plain_read(4'd9, "R8 read back");
  endtask

  task automatic t_success;
    plain_write(4'd1, 16'd7, "R2 setup");
    plain_write(4'd2, 16'h00aa, "R2 setup");
    dcas(4'd1, 4'd2, 16'd7, 16'h00aa, 16'd8, 16'h00bb, 0, "R2");
    plain_read(4'd1, "R2 word A written");
    plain_read(4'd2, "R2 word B written");
  endtask

  task automatic t_fail;
    dcas(4'd1, 4'd2, 16'd7, 16'h00bb, 16'd99, 16'd98, 0, "R3 A mismatch");
    plain_read(4'd1, "R3 word A kept");
    plain_read(4'd2, "R3 word B kept");
    dcas(4'd1, 4'd2, 16'd8, 16'h00aa, 16'd99, 16'd98, 2, "R3 B mismatch");
    plain_read(4'd1, "R3 word A kept");
    plain_read(4'd2, "R3 word B kept");
  endtask

  task automatic t_version_chain;
    for (int v = 0; v < 4; v++)
      dcas(4'd5, 4'd6, v[DW-1:0], model[6], v[DW-1:0] + 16'd1, 16'h100 + v[DW-1:0], 0,
           "R2 version chain");
    dcas(4'd5, 4'd6, 16'd2, model[6], 16'd3, 16'h0, 0, "R3 stale version");
    plain_read(4'd5, "R2 version final");
    plain_read(4'd6, "R3 pointer kept");
  endtask

  task automatic t_same_addr;
    plain_write(4'd12, 16'd40, "R6 setup");
    dcas(4'd12, 4'd12, 16'd40, 16'd41, 16'd1, 16'd2, 0, "R6 one exp mismatch");
    plain_read(4'd12, "R6 unchanged");
    dcas(4'd12, 4'd12, 16'd40, 16'd40, 16'd1, 16'd2, 0, "R6 both match");
    plain_read(4'd12, "R6 second new value kept");
  endtask

  task automatic t_simultaneous;
    @(negedge clk_i);
    preq_valid_i = 1; preq_we_i = 1; preq_addr_i = 4'd14; preq_wdata_i = 16'd77;
    dreq_valid_i = 1; dreq_addr_a_i = 4'd14; dreq_addr_b_i = 4'd15;
    dreq_exp_a_i = 16'd77; dreq_exp_b_i = model[15];
    dreq_new_a_i = 16'd78; dreq_new_b_i = 16'd5;
    @(negedge clk_i);
    preq_valid_i = 0; preq_we_i = 0; dreq_valid_i = 0;
    while (!drsp_valid_o) @(negedge clk_i);
    check(drsp_ok_o == 1'b1, "R9 plain first", drsp_ok_o, 1);
    drsp_ready_i = 1;
    @(negedge clk_i);
    drsp_ready_i = 0;
    model[14] = 16'd78; model[15] = 16'd5;
    plain_read(4'd14, "R9 final A");
  endtask

  task automatic t_holdoff;
    int held;
    plain_write(4'd10, 16'd3, "R4 setup");
    @(negedge clk_i);
    dreq_valid_i = 1; dreq_addr_a_i = 4'd10; dreq_addr_b_i = 4'd11;
    dreq_exp_a_i = 16'd3; dreq_exp_b_i = model[11];
    dreq_new_a_i = 16'd4; dreq_new_b_i = 16'd6;
    @(negedge clk_i);
    dreq_valid_i = 0;
    preq_valid_i = 1; preq_we_i = 1; preq_addr_i = 4'd10; preq_wdata_i = 16'd500;
    held = 0;
    while (!preq_ready_o && held < 20) begin @(negedge clk_i); held++; end
    check(held == 5, "R4 hold-off cycles", held, 5);
    @(negedge clk_i);
    preq_valid_i = 0; preq_we_i = 0;
    check(drsp_ok_o, "R4 atomic ok", drsp_ok_o, 1);
    drsp_ready_i = 1;
    @(negedge clk_i);
    drsp_ready_i = 0;
    model[10] = 16'd500; model[11] = 16'd6;
    plain_read(4'd10, "R4 plain write lands after");
    plain_read(4'd11, "R4 word B");
  endtask

  task automatic t_random;
    for (int n = 0; n < 150; n++) begin
      logic [AW-1:0] a, b;
      logic [DW-1:0] ea, eb;
      a = AW'($urandom_range(0, DEPTH-1));
      b = AW'($urandom_range(0, DEPTH-1));
      case ($urandom_range(0, 3))
        0: plain_write(a, DW'($urandom_range(0, 3)), "R8 random write");
        1: plain_read(a, "R8 random read");
        default: begin
          ea = ($urandom_range(0, 3) != 0) ? model[a] : DW'($urandom_range(0, 3));
          eb = ($urandom_range(0, 3) != 0) ? model[b] : DW'($urandom_range(0, 3));
          dcas(a, b, ea, eb, DW'($urandom_range(0, 7)), DW'($urandom_range(0, 7)),
               $urandom_range(0, 1), "R2 R3 random");
        end
      endcase
    end
    for (int i = 0; i < DEPTH; i++) plain_read(i[AW-1:0], "R2 R3 random final");
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_plain();
    t_success();
    t_fail();
    t_version_chain();
    t_same_addr();
    t_simultaneous();
    t_holdoff();
    t_random();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule